// File: doc/BRIEF.md
# Wake-Up Interrupt Polarity Normalizer

This block sits between a bank of external wake-up interrupt pins and a downstream interrupt controller that only understands rising-edge events and active-high levels. Each pin can be set to one of five trigger kinds: level active-low, level active-high, falling edge, rising edge or both edges. The block resynchronises each pin to the local clock and applies a per-pin inversion. An edge stage then turns every configured trigger into either a single-cycle high pulse or a high level on that pin's own output line. The default bank holds 168 pins.

Software reaches the block through a small word-addressed register port. Enable bits are packed 32 pins to a word. Each pin also has its own trigger word. Turning one pin on or off is done by reading its enable word, changing one bit and writing the word back. When a pin's trigger word is written, the block re-arms that pin's edge history under the new polarity. A polarity change on a steady input therefore produces no output event.

Top module: `wkn_top`

## Requirements
- R1: After reset every output is low, every enable bit reads 0 and every trigger word reads 4 (binary 100, level active-high).
- R2: Word address 4+k holds the enable word k, where pin p is bit p%32 of word p/32. Word address 68+p holds pin p's trigger code in bits [2:0], with the other bits read as 0. Read data shows the addressed word one cycle after the address is presented. Any other address reads 0.
- R3: Writing an enable word changes only the pins in that word. A read-modify-write that changes one bit leaves every other pin's enable and behaviour unchanged.
- R4: A change on a pin input reaches its output through a two-flop synchroniser and one output register. The output changes in the third clock edge after the change, and not earlier.
- R5: Code 100 (level active-high): an enabled pin's output follows the input.
- R6: Code 000 (level active-low): an enabled pin's output is the inverted input.
- R7: Code 110 (rising edge): each 0-to-1 input transition gives exactly one single-cycle output pulse. A 1-to-0 transition gives none.
- R8: Code 010 (falling edge): each 1-to-0 input transition gives exactly one single-cycle output pulse. A 0-to-1 transition gives none.
- R9: Code 111 (both edges): every input transition, in either direction, gives a single-cycle output pulse.
- R10: A pin whose enable bit is 0 drives its output low.
- R11: Codes 001, 011 and 101 are treated as disabled: the output stays low whatever the input does.
- R12: In the cycle after a pin's trigger word is written, that pin's output is low. The pin's edge history is then reloaded from the current input under the new polarity, so a steady input produces no edge event after a polarity change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous wake-up interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | NUM_PINS | Normalized rising-edge or active-high lines |

## Verification
The bench targets the phantom event. A pin in rising-edge mode holds a steady low input and is then rewritten to falling-edge mode. A design that keeps its old edge history would emit a pulse two cycles after the write. A level pin whose code is rewritten must drop low for one cycle and then return high; a design that ignores the write shows no gap. The bench changes one bit of an enable word with a read-modify-write and then exercises the neighbouring pins in that word, which catches a design that clears or shifts other bits. The bench also drives falling transitions into rising pins, rising transitions into falling pins, and inputs into pins with invalid codes. A design with a swapped inversion or a faulty code decode shows a pulse or level there that the bench does not expect.

// File: rtl/wkn_pkg.sv
package wkn_pkg;

    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        TRIG_LVL_LOW  = 3'b000,
        TRIG_FALL     = 3'b010,
        TRIG_LVL_HIGH = 3'b100,
        TRIG_RISE     = 3'b110,
        TRIG_BOTH     = 3'b111
    } trig_e;

    localparam logic [2:0] TRIG_RESET = TRIG_LVL_HIGH;

    typedef struct packed {
        logic valid;
        logic invert;
        logic edge_mode;
        logic both;
    } trig_dec_t;

    // Polarity flip is applied when the top code bit is clear.
    function automatic logic trig_inverts(input logic [2:0] code);
        return ~code[2];
    endfunction

    function automatic trig_dec_t decode_trig(input logic [2:0] code);
        trig_dec_t d;
        d           = '0;
        d.invert    = trig_inverts(code);
        case (code)
            TRIG_LVL_LOW,
            TRIG_LVL_HIGH: d.valid = 1'b1;
            TRIG_FALL,
            TRIG_RISE: begin
                d.valid     = 1'b1;
                d.edge_mode = 1'b1;
            end
            TRIG_BOTH: begin
                d.valid     = 1'b1;
                d.edge_mode = 1'b1;
                d.both      = 1'b1;
            end
            default: d.valid = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wkn_sync.sv
module wkn_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/wkn_regs.sv
module wkn_regs
    import wkn_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 10,
    parameter int EN_BASE  = 4,
    parameter int CFG_BASE = 68
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wr_data,
    output logic [REG_W-1:0]      rd_data,
    output logic [NUM_PINS-1:0]   en_vec,
    output logic [3*NUM_PINS-1:0] cfg_flat,
    output logic [NUM_PINS-1:0]   arm_vec,
    output logic                  arm_inv
);
    logic [NUM_PINS-1:0] en_q;
    logic [2:0]          cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0] cfg_hit;
    logic [REG_W-1:0]    rd_val;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            cfg_hit[p] = wr_en && (int'(addr) == CFG_BASE + p);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                cfg_q[p] <= TRIG_RESET;
            end
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_en && (int'(addr) == EN_BASE + p / REG_W)) begin
                    en_q[p] <= wr_data[p % REG_W];
                end
                if (cfg_hit[p]) begin
                    cfg_q[p] <= wr_data[2:0];
                end
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(addr) == EN_BASE + p / REG_W) begin
                rd_val[p % REG_W] = en_q[p];
            end
            if (int'(addr) == CFG_BASE + p) begin
                rd_val[2:0] = cfg_q[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_val;
        end
    end

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_flat
            assign cfg_flat[3*g +: 3] = cfg_q[g];
        end
    endgenerate

    assign en_vec  = en_q;
    assign arm_vec = cfg_hit;
    assign arm_inv = trig_inverts(wr_data[2:0]);
endmodule

// File: rtl/wkn_lane.sv
module wkn_lane
    import wkn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    input  logic       enable,
    input  logic [2:0] code,
    input  logic       arm,
    input  logic       arm_inv,
    output logic       irq
);
    trig_dec_t dec;
    logic      pol;
    logic      hist_q;
    logic      evt;
    logic      irq_q;

    assign dec = decode_trig(code);
    assign pol = sync_in ^ dec.invert;

    always_comb begin
        if (!dec.valid) begin
            evt = 1'b0;
        end else if (!dec.edge_mode) begin
            evt = pol;
        end else if (dec.both) begin
            evt = pol ^ hist_q;
        end else begin
            evt = pol & ~hist_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (arm) begin
            // Reload history under the incoming polarity; hold output low.
            hist_q <= sync_in ^ arm_inv;
            irq_q  <= 1'b0;
        end else begin
            hist_q <= pol;
            irq_q  <= enable & evt;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/wkn_top.sv
module wkn_top
    import wkn_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    output logic [NUM_PINS-1:0] irq_out
);
    localparam int EN_BASE  = 4;
    localparam int CFG_BASE = 68;

    logic [NUM_PINS-1:0]   pin_sync;
    logic [NUM_PINS-1:0]   en_vec;
    logic [3*NUM_PINS-1:0] cfg_flat;
    logic [NUM_PINS-1:0]   arm_vec;
    logic                  arm_inv;

    wkn_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    wkn_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .EN_BASE  (EN_BASE),
        .CFG_BASE (CFG_BASE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .en_vec   (en_vec),
        .cfg_flat (cfg_flat),
        .arm_vec  (arm_vec),
        .arm_inv  (arm_inv)
    );

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
            wkn_lane u_lane (
                .clk     (clk),
                .rst     (rst),
                .sync_in (pin_sync[g]),
                .enable  (en_vec[g]),
                .code    (cfg_flat[3*g +: 3]),
                .arm     (arm_vec[g]),
                .arm_inv (arm_inv),
                .irq     (irq_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/wkn_chk.sv
module wkn_chk #(
    parameter int NUM_PINS = 168
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_PINS-1:0]   irq_out,
    input logic [NUM_PINS-1:0]   en_vec,
    input logic [NUM_PINS-1:0]   arm_vec,
    input logic [3*NUM_PINS-1:0] cfg_flat
);
    logic [NUM_PINS-1:0] bad_vec;
    logic [NUM_PINS-1:0] single_vec;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            bad_vec[p]    = (cfg_flat[3*p +: 3] == 3'b001) ||
                            (cfg_flat[3*p +: 3] == 3'b011) ||
                            (cfg_flat[3*p +: 3] == 3'b101);
            single_vec[p] = (cfg_flat[3*p +: 3] == 3'b010) ||
                            (cfg_flat[3*p +: 3] == 3'b110);
        end
    end

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_out & ~$past(en_vec)) == '0));

    p_bad_code_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_out & $past(bad_vec)) == '0));

    p_rearm_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (|arm_vec) |=> ((irq_out & $past(arm_vec)) == '0));

    // Single-edge modes (R7 and R8) never pulse two cycles running.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_out & $past(irq_out) & $past(single_vec)) == '0));
endmodule

bind wkn_top wkn_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_out  (irq_out),
    .en_vec   (en_vec),
    .arm_vec  (arm_vec),
    .cfg_flat (cfg_flat)
);

// File: tb/test_wkn_top.sv
`timescale 1ns/1ps
module test_wkn_top;
    localparam int NP  = 168;
    localparam int AW  = 10;
    localparam int CFG = 68;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_in;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [31:0]   wr_data;
    logic [31:0]   rd_data;
    logic [NP-1:0] irq_out;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int          due;
        int          kind;
        int          pin;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    wkn_top #(.NUM_PINS(NP), .ADDR_W(AW)) i_wkn_top (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_out (irq_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every due item away from the active edge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [31:0] act;
                act = (sb[i].kind == 0) ? {31'b0, irq_out[sb[i].pin]} : rd_data;
                checks++;
                if (act !== sb[i].exp) begin
                    errors++;
                    $display("FAIL %s kind %0d pin %0d cycle %0d actual %h expected %h",
                             sb[i].tag, sb[i].kind, sb[i].pin, cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic exp_pin(input int d, input int p, input logic v, input string tag);
        item_t it;
        it.due = cyc + d; it.kind = 0; it.pin = p; it.exp = {31'b0, v}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        item_t it;
        addr = AW'(a);
        it.due = cyc + 1; it.kind = 1; it.pin = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0; pin_in = '0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        chk(irq_out == '0, "R1 outputs", irq_out, '0);
        rd(4, 32'h0, "R1 enable word");
        rd(CFG + 167, 32'h4, "R1 trigger word");
        rd(CFG, 32'h4, "R1 trigger word pin0");
        // R2 unmapped addresses
        rd(0, 32'h0, "R2 unmapped low");
        rd(10, 32'h0, "R2 unmapped gap");
        rd(CFG + 168, 32'h0, "R2 past last pin");

        // Configure: pin3 rise, pin40 fall, pin100 both, pin167 low, pin5 high, pin7 invalid
        wr(CFG + 3, 32'h6);
        wr(CFG + 40, 32'h2);
        wr(CFG + 100, 32'h7);
        wr(CFG + 167, 32'h0);
        wr(CFG + 5, 32'h4);
        wr(CFG + 7, 32'h5);
        wr(4, 32'hA8);
        wr(5, 32'h100);
        wr(7, 32'h10);
        wr(9, 32'h80);
        step(4);
        chk(irq_out[167] == 1'b1, "R6 low input idle", {167'b0, irq_out[167]}, 1);
        chk(irq_out[5] == 1'b0, "R5 idle", {167'b0, irq_out[5]}, 0);
        rd(CFG + 40, 32'h2, "R2 trigger readback");
        rd(9, 32'h80, "R2 enable readback");

        // R7 rising edge, R4 latency
        pin_in[3] = 1'b1;
        exp_pin(2, 3, 1'b0, "R4 not early");
        exp_pin(3, 3, 1'b1, "R7 pulse");
        exp_pin(4, 3, 1'b0, "R7 single cycle");
        step(6);
        pin_in[3] = 1'b0;
        exp_pin(3, 3, 1'b0, "R7 no pulse on fall");
        exp_pin(4, 3, 1'b0, "R7 no pulse on fall");
        step(6);

        // R8 falling edge
        pin_in[40] = 1'b1;
        exp_pin(3, 40, 1'b0, "R8 no pulse on rise");
        exp_pin(4, 40, 1'b0, "R8 no pulse on rise");
        step(6);
        pin_in[40] = 1'b0;
        exp_pin(3, 40, 1'b1, "R8 pulse");
        exp_pin(4, 40, 1'b0, "R8 single cycle");
        step(6);

        // R9 both edges
        pin_in[100] = 1'b1;
        exp_pin(3, 100, 1'b1, "R9 rise pulse");
        exp_pin(4, 100, 1'b0, "R9 single cycle");
        step(6);
        pin_in[100] = 1'b0;
        exp_pin(3, 100, 1'b1, "R9 fall pulse");
        exp_pin(4, 100, 1'b0, "R9 single cycle");
        step(6);

        // R5 level high
        pin_in[5] = 1'b1;
        exp_pin(2, 5, 1'b0, "R4 not early");
        exp_pin(3, 5, 1'b1, "R5 follows");
        exp_pin(8, 5, 1'b1, "R5 holds");
        step(10);
        pin_in[5] = 1'b0;
        exp_pin(3, 5, 1'b0, "R5 drops");
        step(5);

        // R6 level low
        pin_in[167] = 1'b1;
        exp_pin(3, 167, 1'b0, "R6 inverted");
        step(5);
        pin_in[167] = 1'b0;
        exp_pin(3, 167, 1'b1, "R6 inverted");
        step(5);

        // R11 invalid codes
        pin_in[7] = 1'b1;
        exp_pin(3, 7, 1'b0, "R11 code 101");
        exp_pin(6, 7, 1'b0, "R11 code 101");
        step(8);
        wr(CFG + 7, 32'h3);
        step(3);
        pin_in[7] = 1'b0;
        exp_pin(3, 7, 1'b0, "R11 code 011");
        exp_pin(4, 7, 1'b0, "R11 code 011");
        step(6);

        // R10 disabled pin
        pin_in[9] = 1'b1;
        exp_pin(3, 9, 1'b0, "R10 disabled");
        exp_pin(6, 9, 1'b0, "R10 disabled");
        step(8);

        // R3 read-modify-write of word 0
        rd(4, 32'hA8, "R3 read before");
        exp_pin(2, 9, 1'b1, "R3 newly enabled");
        wr(4, 32'h2A8);
        step(3);
        rd(4, 32'h2A8, "R3 read after");
        pin_in[3] = 1'b1;
        exp_pin(3, 3, 1'b1, "R3 neighbour still rising");
        exp_pin(4, 3, 1'b0, "R3 neighbour still rising");
        step(6);
        chk(irq_out[167] == 1'b1, "R3 other word kept", {167'b0, irq_out[167]}, 1);
        pin_in[5] = 1'b1;
        step(4);
        exp_pin(2, 9, 1'b0, "R10 disabled again");
        exp_pin(2, 5, 1'b1, "R3 neighbour kept");
        wr(4, 32'hA8);
        step(4);

        // R12 phantom suppression: steady low on rising pin, switch to falling
        pin_in[3] = 1'b0;
        step(6);
        for (int d = 1; d <= 5; d++) exp_pin(d, 3, 1'b0, "R12 no phantom");
        wr(CFG + 3, 32'h2);
        step(6);
        pin_in[3] = 1'b1;
        exp_pin(3, 3, 1'b0, "R12 new polarity rise");
        step(5);
        pin_in[3] = 1'b0;
        exp_pin(3, 3, 1'b1, "R12 new polarity fall pulse");
        exp_pin(4, 3, 1'b0, "R12 new polarity fall pulse");
        step(6);

        // R12 level pin: forced low one cycle after a write
        exp_pin(1, 5, 1'b0, "R12 forced low");
        exp_pin(2, 5, 1'b1, "R12 level returns");
        wr(CFG + 5, 32'h4);
        step(4);
        pin_in[167] = 1'b1;
        step(5);
        exp_pin(1, 167, 1'b0, "R12 forced low");
        exp_pin(2, 167, 1'b1, "R12 level high after switch");
        wr(CFG + 167, 32'h4);
        step(4);
        rd(CFG + 3, 32'h2, "R2 trigger readback");
        step(5);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule